// File: doc/BRIEF.md
# Single-Cycle 16-bit Processor Core

This block is a small 16-bit processor that completes one instruction on every rising clock edge. Instructions and data sit in two separate word-addressed arrays inside the core, so a fetch and a data access can happen in the same cycle. The datapath has four parts:
- a program counter;
- a register file of eight 16-bit registers;
- a function unit;
- two selectors. The first chooses operand B, either a register or a small constant. The second chooses the value written back, either the function-unit result or the word read from data memory.

A purely combinational decoder derives every control signal straight from opcode bits, so no microcode or state machine is involved.

Both arrays are filled through a plain load port, normally while reset is held. After reset is released the core runs from address 0. It shows each cycle's outcome on observation pins: the fetched word, the program counter, the register write-back and the data-memory access. This lets the surrounding logic follow execution without any handshake.

Top module: `sc16_core`

## Requirements
- R1: While `rst_n` is low the program counter reads 0, all eight registers are cleared and no register or memory write is signalled. After release, the first instruction is fetched from address 0.
- R2: Instruction fields are opcode [15:9], destination [8:6], source A [5:3] and source B or 3-bit operand [2:0]. The write address shown on `rf_wa` equals bits [8:6].
- R3: The control bits depend only on opcode bits:
  - operand-B select is bit 15, and write-back select is bit 13;
  - register write is NOT bit 14, and memory write is NOT bit 15 AND bit 14;
  - PC load is bit 15 AND bit 14, jump select is bit 13, and branch-condition select is bit 9.
  - Register write, memory write and PC load are never active together.
- R4: The function select is bits [12:9], with bit 9 forced to 0 whenever the PC load bit is set. Both branches therefore present R[SA] unchanged on `rf_wd`.
- R5: Arithmetic function selects:
  - 0000 passes A, 0001 gives A+1 and 0110 gives A-1;
  - 0010 gives A+B and 0101 gives A+NOT B+1;
  - all results are modulo 2^16.
  - Opcodes: MOVA 0000000, INC 0000001, ADD 0000010, SUB 0000101, DEC 0000110.
- R6: Logic and move selects:
  - 1000 AND, 1001 OR, 1010 XOR and 1011 NOT A;
  - 1100 passes B, 1101 shifts B right by one, and 1110 shifts B left by one, both logical with a zero fill.
  - Opcodes: AND 0001000, OR 0001001, XOR 0001010, NOT 0001011, MOVB 0001100, SHR 0001101, SHL 0001110. A shift takes its source register from the SB field.
- R7: LDI (1001100) writes the operand bits [2:0] zero-extended to 16 bits. ADI (1000010) writes R[SA] plus that zero-extended operand.
- R8: LD (0010000) writes data word M[R[SA]] into R[DR]. ST (0100000) writes R[SB] into M[R[SA]], with `dm_addr` = R[SA] and `dm_wd` = R[SB]. Only the low MEM_AW address bits index memory.
- R9: Every instruction other than a branch or jump advances the program counter by 1, modulo 2^16.
- R10: BRZ (1100000) moves the PC to PC plus the sign-extended 6-bit offset {IR[8:6],IR[2:0]} when R[SA] is zero, and to PC+1 otherwise.
- R11: BRN (1100001) takes the same offset when bit 15 of R[SA] is 1, and goes to PC+1 otherwise.
- R12: JMP (1110000) loads the PC with R[SA]. Jumps, branches and stores leave the register file unchanged.
- R13: A cycle with `load_en` high writes `load_data` at `load_addr`, into data memory when `load_dmem` is 1 and into instruction memory when it is 0. Instruction fetch uses the low MEM_AW bits of the PC.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset |
| load_en | input | 1 | Write one word into a memory this cycle |
| load_dmem | input | 1 | 1 selects data memory, 0 instruction memory |
| load_addr | input | MEM_AW | Word address for the load |
| load_data | input | 16 | Word to load |
| pc_o | output | 16 | Current program counter |
| instr_o | output | 16 | Instruction fetched at the current PC |
| rf_we_o | output | 1 | Register write at the coming edge |
| rf_wa_o | output | 3 | Register write address |
| rf_wd_o | output | 16 | Write-back value (selector output) |
| dm_we_o | output | 1 | Data memory write at the coming edge |
| dm_addr_o | output | 16 | Data address (source A value) |
| dm_wd_o | output | 16 | Data written on a store (operand B value) |

## Verification
The checker assumes two things about the stimulus. First, every instruction word has been written before reset is released, so the fetched word and the control bits are never unknown. Second, the load port stays quiet while the core runs. The bench meets both by filling all instruction and data words under reset before every program. Random programs draw only from the nineteen defined opcodes and use random register fields and offsets, so backward branches, self-loops and register-indirect jumps all occur. The expected state is tracked by an instruction-level model in the bench that is indexed by opcode rather than by control bits.

// File: rtl/sc16_pkg.sv
package sc16_pkg;

  localparam int WORD_W = 16;
  localparam int REG_AW = 3;
  localparam int OFF_W  = 6;

  typedef enum logic [3:0] {
    FS_PASS_A = 4'b0000,
    FS_INC    = 4'b0001,
    FS_ADD    = 4'b0010,
    FS_ADDC   = 4'b0011,
    FS_ADDNB  = 4'b0100,
    FS_SUB    = 4'b0101,
    FS_DEC    = 4'b0110,
    FS_PASS_A2= 4'b0111,
    FS_AND    = 4'b1000,
    FS_OR     = 4'b1001,
    FS_XOR    = 4'b1010,
    FS_NOT    = 4'b1011,
    FS_PASS_B = 4'b1100,
    FS_SHR    = 4'b1101,
    FS_SHL    = 4'b1110,
    FS_ZERO   = 4'b1111
  } fsel_e;

  typedef struct packed {
    logic [REG_AW-1:0] dst;
    logic [REG_AW-1:0] srca;
    logic [REG_AW-1:0] srcb;
    logic              b_const;
    fsel_e             fsel;
    logic              d_mem;
    logic              reg_wr;
    logic              mem_wr;
    logic              pc_ld;
    logic              jump;
    logic              br_neg;
  } ctrl_t;

endpackage

// File: rtl/sc16_decode.sv
module sc16_decode
  import sc16_pkg::*;
(
  input  logic [WORD_W-1:0] ir,
  output ctrl_t             ctl
);

  logic pc_ld;

  always_comb begin
    pc_ld        = ir[15] & ir[14];
    ctl.dst      = ir[8:6];
    ctl.srca     = ir[5:3];
    ctl.srcb     = ir[2:0];
    ctl.b_const  = ir[15];
    ctl.d_mem    = ir[13];
    ctl.reg_wr   = ~ir[14];
    ctl.mem_wr   = ~ir[15] & ir[14];
    ctl.pc_ld    = pc_ld;
    ctl.jump     = ir[13];
    ctl.br_neg   = ir[9];
    ctl.fsel     = fsel_e'({ir[12:10], ir[9] & ~pc_ld});
  end

endmodule

// File: rtl/sc16_regfile.sv
module sc16_regfile #(
  parameter int W  = 16,
  parameter int AW = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          we,
  input  logic [AW-1:0] wa,
  input  logic [W-1:0]  wd,
  input  logic [AW-1:0] ra,
  input  logic [AW-1:0] rb,
  output logic [W-1:0]  qa,
  output logic [W-1:0]  qb
);

  localparam int NREG = 1 << AW;

  logic [W-1:0] regs [NREG];

  for (genvar g = 0; g < NREG; g++) begin : g_reg
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        regs[g] <= '0;
      end else if (we && (wa == AW'(g))) begin
        regs[g] <= wd;
      end
    end
  end

  assign qa = regs[ra];
  assign qb = regs[rb];

endmodule

// File: rtl/sc16_funit.sv
module sc16_funit
  import sc16_pkg::*;
#(
  parameter int W = 16
) (
  input  fsel_e        fsel,
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  output logic [W-1:0] f
);

  always_comb begin
    unique case (fsel)
      FS_PASS_A:  f = a;
      FS_INC:     f = a + W'(1);
      FS_ADD:     f = a + b;
      FS_ADDC:    f = a + b + W'(1);
      FS_ADDNB:   f = a + ~b;
      FS_SUB:     f = a + ~b + W'(1);
      FS_DEC:     f = a - W'(1);
      FS_PASS_A2: f = a;
      FS_AND:     f = a & b;
      FS_OR:      f = a | b;
      FS_XOR:     f = a ^ b;
      FS_NOT:     f = ~a;
      FS_PASS_B:  f = b;
      FS_SHR:     f = {1'b0, b[W-1:1]};
      FS_SHL:     f = {b[W-2:0], 1'b0};
      FS_ZERO:    f = '0;
      default:    f = '0;
    endcase
  end

endmodule

// File: rtl/sc16_pcunit.sv
module sc16_pcunit #(
  parameter int W     = 16,
  parameter int OFF_W = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             pc_ld,
  input  logic             jump,
  input  logic             br_neg,
  input  logic             flag_n,
  input  logic             flag_z,
  input  logic [OFF_W-1:0] off,
  input  logic [W-1:0]     jaddr,
  output logic [W-1:0]     pc
);

  logic         take;
  logic [W-1:0] off_ext;
  logic [W-1:0] pc_nxt;

  always_comb begin
    take    = br_neg ? flag_n : flag_z;
    off_ext = {{(W-OFF_W){off[OFF_W-1]}}, off};
    if (!pc_ld)    pc_nxt = pc + W'(1);
    else if (jump) pc_nxt = jaddr;
    else if (take) pc_nxt = pc + off_ext;
    else           pc_nxt = pc + W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pc <= '0;
    else        pc <= pc_nxt;
  end

endmodule

// File: rtl/sc16_core.sv
module sc16_core
  import sc16_pkg::*;
#(
  parameter int MEM_AW = 6
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  load_en,
  input  logic                  load_dmem,
  input  logic [MEM_AW-1:0]     load_addr,
  input  logic [WORD_W-1:0]     load_data,
  output logic [WORD_W-1:0]     pc_o,
  output logic [WORD_W-1:0]     instr_o,
  output logic                  rf_we_o,
  output logic [REG_AW-1:0]     rf_wa_o,
  output logic [WORD_W-1:0]     rf_wd_o,
  output logic                  dm_we_o,
  output logic [WORD_W-1:0]     dm_addr_o,
  output logic [WORD_W-1:0]     dm_wd_o
);

  localparam int DEPTH = 1 << MEM_AW;
  localparam int CW    = WORD_W - REG_AW;

  logic [WORD_W-1:0] imem [DEPTH];
  logic [WORD_W-1:0] dmem [DEPTH];

  logic [WORD_W-1:0] pc_q;
  logic [WORD_W-1:0] instr;
  ctrl_t             ctl;
  logic [WORD_W-1:0] bus_a;
  logic [WORD_W-1:0] reg_b;
  logic [WORD_W-1:0] bus_b;
  logic [WORD_W-1:0] const_zf;
  logic [WORD_W-1:0] fu_out;
  logic [WORD_W-1:0] mem_rd;
  logic [WORD_W-1:0] bus_d;
  logic              wr_reg;
  logic              wr_mem;

  assign instr = imem[pc_q[MEM_AW-1:0]];

  sc16_decode u_dec (
    .ir  (instr),
    .ctl (ctl)
  );

  assign wr_reg = ctl.reg_wr & rst_n;
  assign wr_mem = ctl.mem_wr & rst_n;

  sc16_regfile #(.W(WORD_W), .AW(REG_AW)) u_rf (
    .clk   (clk),
    .rst_n (rst_n),
    .we    (wr_reg),
    .wa    (ctl.dst),
    .wd    (bus_d),
    .ra    (ctl.srca),
    .rb    (ctl.srcb),
    .qa    (bus_a),
    .qb    (reg_b)
  );

  assign const_zf = {{CW{1'b0}}, instr[REG_AW-1:0]};
  assign bus_b    = ctl.b_const ? const_zf : reg_b;

  sc16_funit #(.W(WORD_W)) u_fu (
    .fsel (ctl.fsel),
    .a    (bus_a),
    .b    (bus_b),
    .f    (fu_out)
  );

  assign mem_rd = dmem[bus_a[MEM_AW-1:0]];
  assign bus_d  = ctl.d_mem ? mem_rd : fu_out;

  sc16_pcunit #(.W(WORD_W), .OFF_W(OFF_W)) u_pc (
    .clk    (clk),
    .rst_n  (rst_n),
    .pc_ld  (ctl.pc_ld),
    .jump   (ctl.jump),
    .br_neg (ctl.br_neg),
    .flag_n (bus_a[WORD_W-1]),
    .flag_z (bus_a == '0),
    .off    ({instr[8:6], instr[2:0]}),
    .jaddr  (bus_a),
    .pc     (pc_q)
  );

  always_ff @(posedge clk) begin
    if (load_en && !load_dmem) imem[load_addr] <= load_data;
  end

  always_ff @(posedge clk) begin
    if (load_en && load_dmem)  dmem[load_addr] <= load_data;
    else if (wr_mem)           dmem[bus_a[MEM_AW-1:0]] <= bus_b;
  end

  assign pc_o      = pc_q;
  assign instr_o   = instr;
  assign rf_we_o   = wr_reg;
  assign rf_wa_o   = ctl.dst;
  assign rf_wd_o   = bus_d;
  assign dm_we_o   = wr_mem;
  assign dm_addr_o = bus_a;
  assign dm_wd_o   = bus_b;

endmodule

// File: rtl/sc16_core_chk.sv
module sc16_core_chk (
  input logic        clk,
  input logic        rst_n,
  input logic [15:0] pc,
  input logic [15:0] instr,
  input logic [15:0] bus_a,
  input logic        rf_we,
  input logic [2:0]  rf_wa,
  input logic        rw,
  input logic        mw,
  input logic        pl,
  input logic        jb,
  input logic        bc
);

  AST_RESET_PC: assert property (@(posedge clk) !rst_n |=> (pc == 16'd0)); // R1

  AST_WADDR_FIELD: assert property (@(posedge clk) disable iff (!rst_n)
    rf_we |-> (rf_wa == instr[8:6])); // R2

  AST_CTRL_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({rw, mw, pl})); // R3

  AST_PC_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    !pl |=> (pc == $past(pc) + 16'd1)); // R9

  AST_BRZ_TAKEN: assert property (@(posedge clk) disable iff (!rst_n)
    (pl && !jb && !bc && bus_a == 16'd0) |=>
      (pc == $past(pc) + {{10{$past(instr[8])}}, $past(instr[8:6]), $past(instr[2:0])})); // R10

  AST_BRN_SKIP: assert property (@(posedge clk) disable iff (!rst_n)
    (pl && !jb && bc && !bus_a[15]) |=> (pc == $past(pc) + 16'd1)); // R11

  AST_JMP_TARGET: assert property (@(posedge clk) disable iff (!rst_n)
    (pl && jb) |=> (pc == $past(bus_a))); // R12

  AST_NO_RF_ON_PL: assert property (@(posedge clk) disable iff (!rst_n)
    pl |-> !rf_we); // R12

endmodule

bind sc16_core sc16_core_chk u_chk (
  .clk   (clk),
  .rst_n (rst_n),
  .pc    (pc_q),
  .instr (instr),
  .bus_a (bus_a),
  .rf_we (rf_we_o),
  .rf_wa (rf_wa_o),
  .rw    (ctl.reg_wr),
  .mw    (ctl.mem_wr),
  .pl    (ctl.pc_ld),
  .jb    (ctl.jump),
  .bc    (ctl.br_neg)
);

// File: tb/test_sc16_core.sv
module test_sc16_core;

  localparam int AW    = 6;
  localparam int DEPTH = 1 << AW;

  localparam logic [6:0] OP_MOVA = 7'b0000000, OP_INC = 7'b0000001, OP_ADD = 7'b0000010,
                         OP_SUB  = 7'b0000101, OP_DEC = 7'b0000110, OP_AND = 7'b0001000,
                         OP_OR   = 7'b0001001, OP_XOR = 7'b0001010, OP_NOT = 7'b0001011,
                         OP_MOVB = 7'b0001100, OP_SHR = 7'b0001101, OP_SHL = 7'b0001110,
                         OP_LDI  = 7'b1001100, OP_ADI = 7'b1000010, OP_LD  = 7'b0010000,
                         OP_ST   = 7'b0100000, OP_BRZ = 7'b1100000, OP_BRN = 7'b1100001,
                         OP_JMP  = 7'b1110000;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          load_en = 1'b0;
  logic          load_dmem = 1'b0;
  logic [AW-1:0] load_addr = '0;
  logic [15:0]   load_data = '0;
  logic [15:0]   pc_o, instr_o, rf_wd_o, dm_addr_o, dm_wd_o;
  logic          rf_we_o, dm_we_o;
  logic [2:0]    rf_wa_o;

  always #5 clk = ~clk;

  sc16_core #(.MEM_AW(AW)) i_sc16_core (
    .clk(clk), .rst_n(rst_n), .load_en(load_en), .load_dmem(load_dmem),
    .load_addr(load_addr), .load_data(load_data), .pc_o(pc_o), .instr_o(instr_o),
    .rf_we_o(rf_we_o), .rf_wa_o(rf_wa_o), .rf_wd_o(rf_wd_o), .dm_we_o(dm_we_o),
    .dm_addr_o(dm_addr_o), .dm_wd_o(dm_wd_o)
  );

  int n_chk = 0;
  int n_err = 0;
  bit done  = 1'b0;

  logic [15:0] m_reg [8];
  logic [15:0] m_dm  [DEPTH];
  logic [15:0] m_im  [DEPTH];
  logic [15:0] m_pc;
  string       pc_tag;

  task automatic chk(string tag, logic [15:0] act, logic [15:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s pc=%h actual=%h expected=%h", tag, m_pc, act, exp);
    end
  endtask

  function automatic logic [15:0] enc(logic [6:0] op, logic [2:0] d, logic [2:0] a, logic [2:0] b);
    return {op, d, a, b};
  endfunction

  function automatic logic [15:0] encj(logic [6:0] op, logic [5:0] off, logic [2:0] a);
    return {op, off[5:3], a, off[2:0]};
  endfunction

  task automatic start_prog();
    rst_n = 1'b0;
    for (int i = 0; i < 2 * DEPTH; i++) begin
      @(negedge clk);
      load_en   = 1'b1;
      load_dmem = (i >= DEPTH);
      load_addr = AW'(i % DEPTH);
      load_data = (i >= DEPTH) ? m_dm[i - DEPTH] : m_im[i];
    end
    @(negedge clk);
    load_en = 1'b0;
    #1;
    chk("R1 pc", pc_o, 16'd0);
    chk("R1 rf_we", {15'd0, rf_we_o}, 16'd0);
    chk("R1 dm_we", {15'd0, dm_we_o}, 16'd0);
    for (int r = 0; r < 8; r++) m_reg[r] = '0;
    m_pc   = '0;
    pc_tag = "R1 start";
    @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic step();
    logic [15:0] ir, a, b, zf, off, wd, npc;
    logic [6:0]  op;
    logic        we, st, br;
    string       ptag, dtag;
    ir  = m_im[m_pc[AW-1:0]];
    op  = ir[15:9];
    a   = m_reg[ir[5:3]];
    b   = m_reg[ir[2:0]];
    zf  = {13'd0, ir[2:0]};
    off = {{10{ir[8]}}, ir[8:6], ir[2:0]};
    we = 1'b1; st = 1'b0; br = 1'b0; wd = '0; npc = m_pc + 16'd1;
    ptag = "R9"; dtag = "R5";
    case (op)
      OP_MOVA: wd = a;
      OP_INC:  wd = a + 16'd1;
      OP_ADD:  wd = a + b;
      OP_SUB:  wd = a - b;
      OP_DEC:  wd = a - 16'd1;
      OP_AND:  begin wd = a & b;  dtag = "R6"; end
      OP_OR:   begin wd = a | b;  dtag = "R6"; end
      OP_XOR:  begin wd = a ^ b;  dtag = "R6"; end
      OP_NOT:  begin wd = ~a;     dtag = "R6"; end
      OP_MOVB: begin wd = b;      dtag = "R6"; end
      OP_SHR:  begin wd = b >> 1; dtag = "R6"; end
      OP_SHL:  begin wd = b << 1; dtag = "R6"; end
      OP_LDI:  begin wd = zf;     dtag = "R7"; end
      OP_ADI:  begin wd = a + zf; dtag = "R7"; end
      OP_LD:   begin wd = m_dm[a[AW-1:0]]; dtag = "R8"; end
      OP_ST:   begin we = 1'b0; st = 1'b1; end
      OP_BRZ:  begin we = 1'b0; br = 1'b1; ptag = "R10"; if (a == 16'd0) npc = m_pc + off; end
      OP_BRN:  begin we = 1'b0; br = 1'b1; ptag = "R11"; if (a[15]) npc = m_pc + off; end
      OP_JMP:  begin we = 1'b0; ptag = "R12"; npc = a; end
      default: we = 1'b0;
    endcase
    chk({pc_tag, " pc"}, pc_o, m_pc);
    chk("R13 instr", instr_o, ir);
    chk("R3 R14 rf_we", {15'd0, rf_we_o}, {15'd0, we});
    chk("R3 dm_we", {15'd0, dm_we_o}, {15'd0, st});
    if (we) begin
      chk("R2 rf_wa", {13'd0, rf_wa_o}, {13'd0, ir[8:6]});
      chk({dtag, " rf_wd"}, rf_wd_o, wd);
      m_reg[ir[8:6]] = wd;
    end
    if (st) begin
      chk("R8 dm_addr", dm_addr_o, a);
      chk("R8 dm_wd", dm_wd_o, b);
      m_dm[a[AW-1:0]] = b;
    end
    if (br) chk("R4 rf_wd on branch", rf_wd_o, a);
    pc_tag = ptag;
    m_pc   = npc;
  endtask

  task automatic run(int cycles);
    for (int c = 0; c < cycles; c++) begin
      #1;
      step();
      @(negedge clk);
    end
  endtask

  logic [6:0] ops [19] = '{OP_MOVA, OP_INC, OP_ADD, OP_SUB, OP_DEC, OP_AND, OP_OR,
                           OP_XOR, OP_NOT, OP_MOVB, OP_SHR, OP_SHL, OP_LDI, OP_ADI,
                           OP_LD, OP_ST, OP_BRZ, OP_BRN, OP_JMP};

  initial begin
    void'($urandom(32'h5C16_0001));
    // directed program
    for (int i = 0; i < DEPTH; i++) begin
      m_im[i] = enc(OP_BRZ, 3'd0, 3'd0, 3'd0);
      m_dm[i] = 16'(i * 16'h0111);
    end
    m_im[0]  = enc(OP_LDI, 3'd1, 3'd0, 3'd5);
    m_im[1]  = enc(OP_LDI, 3'd2, 3'd0, 3'd3);
    m_im[2]  = enc(OP_SUB, 3'd3, 3'd1, 3'd2);
    m_im[3]  = enc(OP_ADI, 3'd4, 3'd3, 3'd7);
    m_im[4]  = enc(OP_ST,  3'd0, 3'd4, 3'd1);
    m_im[5]  = enc(OP_LD,  3'd5, 3'd4, 3'd0);
    m_im[6]  = enc(OP_SHL, 3'd6, 3'd0, 3'd5);
    m_im[7]  = enc(OP_NOT, 3'd7, 3'd6, 3'd0);
    m_im[8]  = encj(OP_BRN, 6'd3, 3'd7);
    m_im[9]  = enc(OP_LDI, 3'd1, 3'd0, 3'd0);
    m_im[10] = enc(OP_LDI, 3'd1, 3'd0, 3'd0);
    m_im[11] = encj(OP_BRZ, 6'd2, 3'd0);
    m_im[12] = enc(OP_LDI, 3'd1, 3'd0, 3'd0);
    m_im[13] = encj(OP_BRZ, 6'd5, 3'd1);
    m_im[14] = enc(OP_DEC, 3'd2, 3'd2, 3'd0);
    m_im[15] = encj(OP_BRN, 6'h3C, 3'd2);
    m_im[16] = enc(OP_LDI, 3'd3, 3'd0, 3'd5);
    m_im[17] = enc(OP_SHL, 3'd3, 3'd0, 3'd3);
    m_im[18] = enc(OP_SHL, 3'd3, 3'd0, 3'd3);
    m_im[19] = enc(OP_JMP, 3'd0, 3'd3, 3'd0);
    m_im[20] = enc(OP_SHR, 3'd4, 3'd0, 3'd4);
    m_im[21] = enc(OP_XOR, 3'd5, 3'd7, 3'd1);
    m_im[22] = encj(OP_BRZ, 6'd0, 3'd0);
    start_prog();
    run(40);
    chk("R10 self loop pc", pc_o, 16'd22);
    // random programs
    for (int p = 0; p < 6; p++) begin
      for (int i = 0; i < DEPTH; i++) begin
        logic [6:0] op;
        op = ops[$urandom % 19];
        m_im[i] = {op, 9'($urandom)};
        m_dm[i] = ($urandom % 4 == 0) ? 16'd0 : 16'($urandom);
      end
      start_prog();
      run(300);
    end
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_err++;
      $display("FAIL watchdog: run did not complete");
      $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
      $finish;
    end
  end

endmodule